// File: doc/BRIEF.md
# Page-Striped Parity Address Generator

This block turns a physical data line address into the three places a redundancy engine must touch for that line. The first is the memory module and in-module line offset that hold the data. The second is the line holding its checksum, together with the slot inside that line. The third is the module and offset of the parity line that protects it. Data is spread over the modules one whole 4 KB page at a time. Each stripe holds one page on every module: one of those pages holds parity and the rest hold data. The parity page moves one module further along with each successive stripe.

Each line has a 32-bit checksum, and sixteen of them are packed into one 64-byte checksum line in a separate region whose base is fixed at build time. A request is a line index presented with a one-cycle strobe. All three locations appear together on registered outputs in the next cycle, and they stay there until the next request.

Top module: `pgpar_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and every location output is 0 until the first request.
- R2: A request strobed in one cycle produces `out_valid` high with its locations in the next cycle. Strobes in consecutive cycles each produce their own result in consecutive cycles.
- R3: In a cycle with no strobe, `out_valid` falls in the next cycle and all location outputs keep their previous values.
- R4: The low 6 bits of the line index are the line offset within a 4 KB page. The remaining upper bits are the page number.
- R5: The stripe number is the page number divided by (modules − 1). The data slot within the stripe is the page number modulo (modules − 1).
- R6: The parity module for a stripe is the stripe number modulo the module count, so the parity page advances by one module per stripe.
- R7: The data module is the data slot when the slot is below the parity module, and slot + 1 otherwise. It therefore never equals the parity module.
- R8: The in-module line offset is stripe × 64 + line offset. The parity line uses the same offset on the parity module.
- R9: The checksum line address is the checksum base plus the line index shifted right by 4.
- R10: The checksum slot is the line index modulo 16.
- R11: The highest line index maps without wrap or truncation of any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | LINE_ADDR_W | Physical data line index |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| data_mod | output | MOD_W | Module holding the data page |
| data_off | output | LINE_ADDR_W | Line offset of the data inside its module |
| par_mod | output | MOD_W | Module holding the parity page |
| par_off | output | LINE_ADDR_W | Line offset of the parity line inside its module |
| csum_line | output | LINE_ADDR_W | Address of the line holding the checksum |
| csum_slot | output | CS_SH | Checksum slot within that line |

## Verification
Two things can happen in the same cycle. A new strobe can arrive while the result of the previous request is being presented, and in that same cycle the parity rotation can move the parity page onto the module that the previous request used for data. The bench provokes both by sweeping pages across several full rotations with strobes in consecutive cycles. Each result is compared, at the cycle after its own strobe, with values computed arithmetically from the line index. Idle gaps between bursts confirm that the outputs hold their values.

// File: rtl/pgpar_pkg.sv
// Package: shared helpers for the page-striped parity address generator.
// Assumes slot and parity indices are small non-negative integers.
package pgpar_pkg;

    // Map a data slot within a stripe to a module index, stepping over the parity module.
    function automatic int unsigned skip_parity(int unsigned slot, int unsigned par);
        return (slot < par) ? slot : slot + 1;
    endfunction

endpackage

// File: rtl/pgpar_stripe_map.sv
// Module: pgpar_stripe_map
// Splits a page number into stripe and data slot. It then derives the rotating
// parity module, the data module that skips the parity module, and the offset
// inside a module, which is shared by data and parity.
// Assumes NUM_MODS >= 2; one page per module per stripe.
module pgpar_stripe_map #(
    parameter int NUM_MODS = 4,
    parameter int PAGE_W   = 14,
    parameter int LOFF_W   = 6,
    parameter int MOD_W    = 2
) (
    input  logic [PAGE_W-1:0]        page,
    input  logic [LOFF_W-1:0]        line_off,
    output logic [MOD_W-1:0]         data_mod,
    output logic [MOD_W-1:0]         par_mod,
    output logic [PAGE_W+LOFF_W-1:0] mod_off
);
    localparam int              DPS   = NUM_MODS - 1;
    localparam logic [PAGE_W-1:0] DPS_P = PAGE_W'(DPS);
    localparam bit              POW2  = ((NUM_MODS & (NUM_MODS - 1)) == 0);

    logic [PAGE_W-1:0] stripe;
    logic [MOD_W-1:0]  slot;

    // Stripe number and data slot inside the stripe.
    always_comb begin
        stripe = page / DPS_P;
        slot   = MOD_W'(page % DPS_P);
    end

    // Parity rotation: a bit slice for power-of-two module counts, a modulo otherwise.
    generate
        if (POW2) begin : g_rot_slice
            assign par_mod = stripe[MOD_W-1:0];
        end else begin : g_rot_mod
            localparam logic [PAGE_W-1:0] NM_P = PAGE_W'(NUM_MODS);
            assign par_mod = MOD_W'(stripe % NM_P);
        end
    endgenerate

    // Data module: slots ascend across modules and step over the parity module.
    always_comb begin
        data_mod = MOD_W'(pgpar_pkg::skip_parity(32'(slot), 32'(par_mod)));
    end

    // Each module holds one page per stripe, so the offset is stripe pages plus the line.
    assign mod_off = {stripe, line_off};

endmodule

// File: rtl/pgpar_csum_map.sv
// Module: pgpar_csum_map
// Locates the packed checksum of a line: which checksum line holds it and which slot.
// Assumes a power-of-two number of checksums per line and a base that leaves room for the region.
module pgpar_csum_map #(
    parameter int                     LINE_ADDR_W = 20,
    parameter int                     CS_SH       = 4,
    parameter logic [LINE_ADDR_W-1:0] CSUM_BASE   = '0
) (
    input  logic [LINE_ADDR_W-1:0] addr,
    output logic [LINE_ADDR_W-1:0] csum_line,
    output logic [CS_SH-1:0]       csum_slot
);
    // Checksum line is the region base plus the line index divided by the pack factor.
    always_comb begin
        csum_line = CSUM_BASE + (addr >> CS_SH);
        csum_slot = addr[CS_SH-1:0];
    end

endmodule

// File: rtl/pgpar_addr_gen.sv
// Module: pgpar_addr_gen (top)
// Maps a data line index to its data location, its checksum line and slot, and its
// parity location. Pages are interleaved across modules and parity rotates per stripe.
// Results are registered and valid one cycle after the strobe, and held between requests.
// Assumes PAGE_BYTES, LINE_BYTES and the checksum pack factor are powers of two.
module pgpar_addr_gen #(
    parameter int                     NUM_MODS    = 4,
    parameter int                     LINE_ADDR_W = 20,
    parameter int                     PAGE_BYTES  = 4096,
    parameter int                     LINE_BYTES  = 64,
    parameter int                     CSUM_BITS   = 32,
    parameter logic [LINE_ADDR_W-1:0] CSUM_BASE   = 20'hC0000,
    localparam int                    MOD_W       = (NUM_MODS > 2) ? $clog2(NUM_MODS) : 1,
    localparam int                    CS_SH       = $clog2(LINE_BYTES * 8 / CSUM_BITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LINE_ADDR_W-1:0] in_addr,
    output logic                   out_valid,
    output logic [MOD_W-1:0]       data_mod,
    output logic [LINE_ADDR_W-1:0] data_off,
    output logic [MOD_W-1:0]       par_mod,
    output logic [LINE_ADDR_W-1:0] par_off,
    output logic [LINE_ADDR_W-1:0] csum_line,
    output logic [CS_SH-1:0]       csum_slot
);
    localparam int PG_SH  = $clog2(PAGE_BYTES / LINE_BYTES);
    localparam int PAGE_W = LINE_ADDR_W - PG_SH;

    logic [MOD_W-1:0]       nx_data_mod;
    logic [MOD_W-1:0]       nx_par_mod;
    logic [LINE_ADDR_W-1:0] nx_off;
    logic [LINE_ADDR_W-1:0] nx_csum_line;
    logic [CS_SH-1:0]       nx_csum_slot;

    pgpar_stripe_map #(
        .NUM_MODS (NUM_MODS),
        .PAGE_W   (PAGE_W),
        .LOFF_W   (PG_SH),
        .MOD_W    (MOD_W)
    ) stripe_i (
        .page     (in_addr[LINE_ADDR_W-1:PG_SH]),
        .line_off (in_addr[PG_SH-1:0]),
        .data_mod (nx_data_mod),
        .par_mod  (nx_par_mod),
        .mod_off  (nx_off)
    );

    pgpar_csum_map #(
        .LINE_ADDR_W (LINE_ADDR_W),
        .CS_SH       (CS_SH),
        .CSUM_BASE   (CSUM_BASE)
    ) csum_i (
        .addr      (in_addr),
        .csum_line (nx_csum_line),
        .csum_slot (nx_csum_slot)
    );

    // Output register: capture locations on a strobe, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            data_mod  <= '0;
            data_off  <= '0;
            par_mod   <= '0;
            par_off   <= '0;
            csum_line <= '0;
            csum_slot <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                data_mod  <= nx_data_mod;
                data_off  <= nx_off;
                par_mod   <= nx_par_mod;
                par_off   <= nx_off;
                csum_line <= nx_csum_line;
                csum_slot <= nx_csum_slot;
            end
        end
    end

endmodule

// File: rtl/pgpar_addr_gen_chk.sv
// Module: pgpar_addr_gen_chk
// Checker bound to pgpar_addr_gen: timing of results, holding when idle, and
// structural relations between the data, parity and checksum outputs.
module pgpar_addr_gen_chk #(
    parameter int LINE_ADDR_W = 20,
    parameter int MOD_W       = 2,
    parameter int CS_SH       = 4,
    parameter int PG_SH       = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [LINE_ADDR_W-1:0] in_addr,
    input logic                   out_valid,
    input logic [MOD_W-1:0]       data_mod,
    input logic [LINE_ADDR_W-1:0] data_off,
    input logic [MOD_W-1:0]       par_mod,
    input logic [LINE_ADDR_W-1:0] par_off,
    input logic [CS_SH-1:0]       csum_slot
);
    // R2: a strobe yields a valid result in the next cycle.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3: no strobe means no result and held outputs.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(data_mod) && $stable(data_off)
                       && $stable(par_mod) && $stable(par_off) && $stable(csum_slot)));

    // R4: the page line offset passes through to the module offset.
    assert_line_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> data_off[PG_SH-1:0] == $past(in_addr[PG_SH-1:0]));

    // R7: data never lands on the parity module.
    assert_parity_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> data_mod != par_mod);

    // R8: data and parity share one in-module offset.
    assert_shared_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> data_off == par_off);

    // R10: checksum slot is the line index modulo the pack factor.
    assert_csum_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> csum_slot == $past(in_addr[CS_SH-1:0]));

endmodule

bind pgpar_addr_gen pgpar_addr_gen_chk #(
    .LINE_ADDR_W (LINE_ADDR_W),
    .MOD_W       (MOD_W),
    .CS_SH       (CS_SH),
    .PG_SH       (PG_SH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .data_mod  (data_mod),
    .data_off  (data_off),
    .par_mod   (par_mod),
    .par_off   (par_off),
    .csum_slot (csum_slot)
);

// File: tb/pgpar_addr_gen_tb.sv
// Bench for pgpar_addr_gen: sweeps pages over several parity rotations with
// back-to-back strobes and idle gaps, and compares against arithmetic expectations.
module pgpar_addr_gen_tb_top;
    localparam int NM    = 4;
    localparam int AW    = 20;
    localparam int MW    = 2;
    localparam int CSW   = 4;
    localparam int unsigned BASE = 32'hC0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          out_valid;
    logic [MW-1:0] data_mod;
    logic [AW-1:0] data_off;
    logic [MW-1:0] par_mod;
    logic [AW-1:0] par_off;
    logic [AW-1:0] csum_line;
    logic [CSW-1:0] csum_slot;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    pgpar_addr_gen dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_addr (in_addr),
        .out_valid (out_valid), .data_mod (data_mod), .data_off (data_off),
        .par_mod (par_mod), .par_off (par_off), .csum_line (csum_line),
        .csum_slot (csum_slot)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Compare one value and record the outcome.
    task automatic check(string req, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe one address; sample its result at the next falling edge.
    task automatic req(int unsigned a);
        int unsigned page, lo, s, k, pm, dm, off;
        in_valid = 1'b1;
        in_addr  = AW'(a);
        @(negedge clk);
        page = a >> 6;
        lo   = a & 63;
        s    = page / (NM - 1);
        k    = page % (NM - 1);
        pm   = s % NM;
        dm   = (k < pm) ? k : k + 1;
        off  = s * 64 + lo;
        check("R2 valid",       32'(out_valid), 1);
        check("R5/R7 data_mod", 32'(data_mod),  dm);
        check("R6 par_mod",     32'(par_mod),   pm);
        check("R4/R8 data_off", 32'(data_off),  off);
        check("R8 par_off",     32'(par_off),   off);
        check("R9 csum_line",   32'(csum_line), (BASE + (a >> 4)) & 32'hFFFFF);
        check("R10 csum_slot",  32'(csum_slot), a & 15);
    endtask

    // One idle cycle: result gone, locations held.
    task automatic idle_check();
        logic [MW-1:0] dm0;
        logic [AW-1:0] off0;
        logic [AW-1:0] cl0;
        dm0 = data_mod; off0 = data_off; cl0 = csum_line;
        in_valid = 1'b0;
        in_addr  = ~in_addr;
        @(negedge clk);
        check("R3 valid low",  32'(out_valid), 0);
        check("R3 hold mod",   32'(data_mod),  32'(dm0));
        check("R3 hold off",   32'(data_off),  32'(off0));
        check("R3 hold csum",  32'(csum_line), 32'(cl0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state.
        check("R1 valid",     32'(out_valid), 0);
        check("R1 data_mod",  32'(data_mod),  0);
        check("R1 data_off",  32'(data_off),  0);
        check("R1 par_mod",   32'(par_mod),   0);
        check("R1 csum_line", 32'(csum_line), 0);
        check("R1 csum_slot", 32'(csum_slot), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", 32'(out_valid), 0);
        check("R1 held zero",           32'(csum_line), 0);

        // R5 R6 R7: sweep 48 pages (16 stripes, four full rotations) back to back.
        for (int p = 0; p < 48; p++) begin
            req(p * 64);
            req(p * 64 + 1);
            req(p * 64 + 17);
            req(p * 64 + 63);
            if (p % 5 == 4) idle_check();
        end

        // R9 R10: checksum pack boundary.
        req(15);
        req(16);
        idle_check();
        // R11: top of address space.
        req(32'hFFFFF);
        req(32'hFFFC0);
        idle_check();
        // R2: alternating strobes.
        req(32'h12345);
        idle_check();
        req(32'h0ABCD);

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule